// File: doc/BRIEF.md
# Multi-Channel Interval and Timestamp Timer

This peripheral gives a processor two time services behind one small register window. An event channel counts down from a programmed delay and pulses an interrupt line when the delay runs out. It can stop after one expiry or keep firing at a fixed period. A timestamp channel counts up without end at a selectable rate, and software reads it to measure elapsed time. One control word holds the enable, mode and rate-select fields for both channels.

A prescaler inside the block divides the system clock by `TICK_DIV` to make a one-microsecond tick. It then divides that tick by ten, three times over, to make coarser ticks. Each channel picks its rate from this set. Registers are written through a single-cycle write strobe. Reads are combinational from the address.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, the event delay register (offset 4) and the timestamp register (offset 20) read 0, and `irq_o` is low.
- R2: The control word at offset 0 stores only these bits: bits 1:0 (event rate), bits 10:8 (timestamp rate), bit 12 (event periodic), bit 16 (event enable) and bit 20 (timestamp enable). Every other bit ignores writes and reads back 0, so writing all ones reads back 0x00111703.
- R3: The event delay register at offset 4 keeps the low 16 bits of a write. Its upper bits read 0.
- R4: In one-shot mode (bit 12 = 0), a 0-to-1 write of bit 16 with delay N (1 to 0xFFFE) gives exactly one interrupt, N ticks later. After that the channel stops counting.
- R5: In periodic mode (bit 12 = 1), interrupts repeat every N ticks with no further writes.
- R6: Each expiry drives `irq_o` high for exactly one clock cycle.
- R7: Clearing bit 16 stops the event channel, and no interrupt follows. Setting bit 16 again restarts the count from the full programmed delay, so the first interrupt comes after N ticks.
- R8: The event rate code in bits 1:0 selects the tick length: 0 is 1 µs, 1 is 10 µs, 2 is 100 µs and 3 is 1 ms. One tick lasts TICK_DIV·10^code clock cycles.
- R9: While bit 20 is set, the 32-bit timestamp goes up by one per selected tick. The code in bits 10:8 selects the rate: 0 counts every clock, 1 is 1 µs, 2 is 10 µs, 3 is 100 µs, 4 is 1 ms, and codes 5 to 7 hold the count.
- R10: While bit 20 is clear, the timestamp holds its value. A write to offset 20 loads the written value into the timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_o | output | 1 | Event channel expiry pulse |

## Verification
A wrong countdown value shows up as a wrong spacing between interrupt pulses. The spacing is measured exactly in periodic mode, so an off-by-one in reload or rate selection appears at the second expiry. A flag that stays armed after a one-shot expiry, or after a disable, produces an extra pulse within N ticks. A timestamp that counts wrong shows up as a wrong difference between two reads taken a known number of cycles apart. The bench can see this within a few microsecond ticks.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int unsigned EVT_CH      = 0;
    localparam int unsigned TS_CH       = 4;
    localparam int unsigned ADDR_W      = 5;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;
    localparam logic [ADDR_W-1:0] ADDR_EVT  = ADDR_W'((EVT_CH + 1) * 4);
    localparam logic [ADDR_W-1:0] ADDR_TS   = ADDR_W'((TS_CH + 1) * 4);

    localparam int unsigned EVT_TB_LSB  = 2 * EVT_CH;
    localparam int unsigned TS_TB_LSB   = 2 * TS_CH;
    localparam int unsigned EVT_TB_W    = 2;
    localparam int unsigned TS_TB_W     = 3;
    localparam int unsigned EVT_PER_BIT = 12 + EVT_CH;
    localparam int unsigned EVT_EN_BIT  = 16 + EVT_CH;
    localparam int unsigned TS_EN_BIT   = 16 + TS_CH;

    localparam logic [31:0] CTRL_MASK =
        (32'd3 << EVT_TB_LSB) | (32'd7 << TS_TB_LSB) |
        (32'd1 << EVT_PER_BIT) | (32'd1 << EVT_EN_BIT) | (32'd1 << TS_EN_BIT);

    localparam int unsigned NUM_TB   = 4;           // 1us, 10us, 100us, 1ms
    localparam int unsigned DECADES  = NUM_TB - 1;
    localparam int unsigned EVT_CNT_W = 16;
    localparam int unsigned TS_W      = 32;

    typedef struct packed {
        logic                 armed;
        logic [EVT_CNT_W-1:0] cnt;
        logic                 irq;
    } evt_state_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int unsigned TICK_DIV = 200,
    parameter int unsigned DECADES  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DECADES:0] tick
);
    localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DIV_W-1:0] div_q, div_d;

    assign tick[0] = (div_q == DIV_W'(TICK_DIV - 1));

    always_comb begin
        div_d = tick[0] ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    for (genvar k = 0; k < DECADES; k++) begin : g_decade
        logic [3:0] dec_q, dec_d;

        assign tick[k+1] = tick[k] && (dec_q == 4'd9);

        always_comb begin
            dec_d = dec_q;
            if (tick[k]) dec_d = (dec_q == 4'd9) ? 4'd0 : dec_q + 4'd1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dec_q <= '0;
            else        dec_q <= dec_d;
        end
    end
endmodule

// File: rtl/tt_event_chan.sv
module tt_event_chan
    import tt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 en_d,
    input  logic                 en_q,
    input  logic                 periodic,
    input  logic [EVT_CNT_W-1:0] reload,
    output logic                 irq,
    output logic                 armed
);
    evt_state_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (!en_d) begin
            s_d.armed = 1'b0;
        end else if (!en_q) begin
            s_d.armed = 1'b1;
            s_d.cnt   = reload;
        end else if (s_q.armed && tick) begin
            if (s_q.cnt <= EVT_CNT_W'(1)) begin
                s_d.irq = 1'b1;
                if (periodic) s_d.cnt   = reload;
                else          s_d.armed = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq   = s_q.irq;
    assign armed = s_q.armed;
endmodule

// File: rtl/tt_stamp_chan.sv
module tt_stamp_chan
    import tt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    output logic [TS_W-1:0] count
);
    logic [TS_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (en && tick)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
#(
    parameter int unsigned TICK_DIV = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq_o
);
    typedef struct packed {
        logic [31:0]          ctrl;
        logic [EVT_CNT_W-1:0] reload;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == ADDR_CTRL) r_d.ctrl   = wdata & CTRL_MASK;
            if (addr == ADDR_EVT)  r_d.reload = wdata[EVT_CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    logic [NUM_TB-1:0]   tb_tick;
    logic [EVT_TB_W-1:0] evt_code;
    logic [TS_TB_W-1:0]  ts_code;
    logic                evt_tick, ts_tick;
    logic                evt_en_q, evt_en_d, evt_per, ts_en;
    logic                evt_armed, stamp_load;
    logic [TS_W-1:0]     stamp;

    tt_prescaler #(.TICK_DIV(TICK_DIV), .DECADES(DECADES)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tb_tick)
    );

    assign evt_code   = r_q.ctrl[EVT_TB_LSB +: EVT_TB_W];
    assign ts_code    = r_q.ctrl[TS_TB_LSB +: TS_TB_W];
    assign evt_en_q   = r_q.ctrl[EVT_EN_BIT];
    assign evt_en_d   = r_d.ctrl[EVT_EN_BIT];
    assign evt_per    = r_q.ctrl[EVT_PER_BIT];
    assign ts_en      = r_q.ctrl[TS_EN_BIT];
    assign evt_tick   = tb_tick[evt_code];
    assign stamp_load = wr_en && (addr == ADDR_TS);

    always_comb begin
        if (ts_code == '0)                           ts_tick = 1'b1;
        else if (32'(ts_code) <= NUM_TB)             ts_tick = tb_tick[ts_code - 1'b1];
        else                                         ts_tick = 1'b0;
    end

    tt_event_chan u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (evt_tick),
        .en_d    (evt_en_d),
        .en_q    (evt_en_q),
        .periodic(evt_per),
        .reload  (r_q.reload),
        .irq     (irq_o),
        .armed   (evt_armed)
    );

    tt_stamp_chan u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ts_en),
        .tick    (ts_tick),
        .load    (stamp_load),
        .load_val(wdata),
        .count   (stamp)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) rdata = r_q.ctrl;
        if (addr == ADDR_EVT)  rdata = 32'(r_q.reload);
        if (addr == ADDR_TS)   rdata = stamp;
    end
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        evt_en,
    input logic        evt_per,
    input logic        armed,
    input logic        ts_en,
    input logic        ts_wr,
    input logic [31:0] stamp
);
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_IRQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> evt_en); // R7

    AST_DISABLED_NOT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_en |-> !armed); // R7

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(evt_per)) |-> !armed); // R4

    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ts_en) && !$past(ts_wr)) |->
        (stamp == $past(stamp) || stamp == $past(stamp) + 32'd1)); // R9

    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ts_en) && !$past(ts_wr)) |-> $stable(stamp)); // R10
endmodule

bind tick_timer tick_timer_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq_o),
    .evt_en (evt_en_q),
    .evt_per(evt_per),
    .armed  (evt_armed),
    .ts_en  (ts_en),
    .ts_wr  (stamp_load),
    .stamp  (stamp)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    localparam int unsigned DIV = 4;
    localparam logic [31:0] EN_E  = 32'h0001_0000;
    localparam logic [31:0] PER_E = 32'h0000_1000;
    localparam logic [31:0] EN_T  = 32'h0010_0000;

    typedef struct packed {
        logic [1:0]  code;
        logic [15:0] n;
        logic [15:0] gap;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 16'd1, 16'd4},
        '{2'd0, 16'd3, 16'd12},
        '{2'd0, 16'd5, 16'd20},
        '{2'd1, 16'd2, 16'd80},
        '{2'd2, 16'd1, 16'd400},
        '{2'd3, 16'd1, 16'd4000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tick_timer #(.TICK_DIV(DIV)) u_tick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_irq(input int lim, output int t, output bit found);
        found = 0; t = 0;
        for (int i = 0; i < lim; i++) begin
            if (irq_o) begin found = 1; t = cyc; break; end
            @(negedge clk);
        end
    endtask

    task automatic count_irq(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (irq_o) c++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, a0, b0;
        int t1, t2, c;
        bit f1, f2;

        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'd0, v);  chk(v == 0, "R1 ctrl", v, 0);
        rd(5'd4, v);  chk(v == 0, "R1 delay", v, 0);
        rd(5'd20, v); chk(v == 0, "R1 stamp", v, 0);
        chk(irq_o == 1'b0, "R1 irq", 32'(irq_o), 0);

        // R2 unused control bits
        wr(5'd0, 32'hFFFF_FFFF);
        rd(5'd0, v); chk(v == 32'h0011_1703, "R2 mask", v, 32'h0011_1703);
        wr(5'd0, 32'h0);

        // R3 delay register width
        wr(5'd4, 32'h0001_ABCD);
        rd(5'd4, v); chk(v == 32'h0000_ABCD, "R3 delay", v, 32'h0000_ABCD);

        // R5 / R8 / R6 periodic spacing table
        foreach (VECS[i]) begin
            wr(5'd4, 32'(VECS[i].n));
            wr(5'd0, EN_E | PER_E | 32'(VECS[i].code));
            wait_irq(20000, t1, f1);
            @(negedge clk);
            chk(irq_o == 1'b0, "R6 pulse width", 32'(irq_o), 0);
            wait_irq(20000, t2, f2);
            chk(f1 && f2 && (t2 - t1) == int'(VECS[i].gap), "R5 R8 period",
                32'(t2 - t1), 32'(VECS[i].gap));
            wr(5'd0, 32'h0);
        end

        // R4 one-shot fires once
        wr(5'd4, 32'd3);
        wr(5'd0, EN_E);
        count_irq(80, c);
        chk(c == 1, "R4 one-shot count", 32'(c), 1);
        wr(5'd0, 32'h0);

        // R4 boundary: delay 1
        wr(5'd4, 32'd1);
        wr(5'd0, EN_E);
        count_irq(40, c);
        chk(c == 1, "R4 delay one", 32'(c), 1);
        wr(5'd0, 32'h0);

        // R7 disable stops, re-enable restarts full delay
        wr(5'd4, 32'd2);
        wr(5'd0, EN_E | PER_E);
        wait_irq(200, t1, f1);
        @(negedge clk);
        wr(5'd0, PER_E);
        count_irq(80, c);
        chk(f1 && c == 0, "R7 stopped", 32'(c), 0);
        wr(5'd0, EN_E | PER_E);
        c = 0;
        for (int i = 1; i <= 40; i++) begin
            if (irq_o) begin c = i; break; end
            @(negedge clk);
        end
        chk(c >= 5 && c <= 8, "R7 restart delay", 32'(c), 8);
        wr(5'd0, 32'h0);

        // R10 load and hold while disabled
        wr(5'd20, 32'h1234_5678);
        rd(5'd20, v); chk(v == 32'h1234_5678, "R10 load", v, 32'h1234_5678);
        repeat (20) @(negedge clk);
        rd(5'd20, v); chk(v == 32'h1234_5678, "R10 hold", v, 32'h1234_5678);

        // R9 timestamp rates
        wr(5'd0, EN_T);
        rd(5'd20, a0); repeat (10) @(negedge clk); rd(5'd20, b0);
        chk(b0 - a0 == 10, "R9 sysclk rate", b0 - a0, 10);
        wr(5'd0, EN_T | 32'h100);
        rd(5'd20, a0); repeat (40) @(negedge clk); rd(5'd20, b0);
        chk(b0 - a0 == 10, "R9 1us rate", b0 - a0, 10);
        wr(5'd0, EN_T | 32'h200);
        rd(5'd20, a0); repeat (400) @(negedge clk); rd(5'd20, b0);
        chk(b0 - a0 == 10, "R9 10us rate", b0 - a0, 10);
        wr(5'd0, EN_T | 32'h500);
        rd(5'd20, a0); repeat (50) @(negedge clk); rd(5'd20, b0);
        chk(b0 - a0 == 0, "R9 code five holds", b0 - a0, 0);
        wr(5'd0, 32'h0);
        rd(5'd20, a0); repeat (30) @(negedge clk); rd(5'd20, b0);
        chk(b0 == a0, "R10 disabled hold", b0, a0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule